// File: doc/BRIEF.md
# Frame-Synchronous Line Control Register

This block holds the control settings of a network-termination line interface and makes host writes take effect only at a TDM frame boundary. A host writes bytes through a simple strobe-and-data port at any time. Each write is kept in a staging register. On the frame-sync pulse the most recent staged byte is moved into the active register, and the staged copy is then marked consumed.

The lowest bit of each written byte chooses where the byte goes. A byte with that bit clear updates the control fields: activation and deactivation requests, D-channel placement, timing mode, the transmitted M/S bit, the frame-half indication and the multiframe force. A byte with that bit set replaces a separate diagnostic register, and the control fields stay as they are. Activation and deactivation requests are not held as levels. Each one appears as a pulse that lasts exactly one frame, and it goes to the downstream activation state machine. The block also derives the transmitted Fa and N bits from the multiframe force and the frame half.

Top module: `frame_line_ctrl`

## Requirements
- R1: After a synchronous reset, all outputs are 0 except `n_bit`, which is 1. This includes `diag_q`.
- R2: A write has no effect on any output until the next rising clock edge at which `frame_sync` is high. The committed values appear in the cycle after that edge.
- R3: When several writes occur between two frame-sync edges, only the last one is committed.
- R4: A committed control byte (bit 0 = 0) with bit 7 set and bit 6 clear raises `act_req`. A committed control byte with bit 6 set raises `deact_req`. Either request stays high for exactly one frame and clears at the next frame-sync edge. A control byte with both bits clear raises neither request.
- R5: When bits 7 and 6 are both set, only `deact_req` is raised. The two requests are never high together.
- R6: A committed control byte loads `dch_b1` from bit 5 (1 = 64 kbit/s in the B1 slot), `timing_adapt` from bit 4 (1 = adaptive), `ms_bit` from bit 3 and `half_sel` from bit 2. These values are held until the next control commit.
- R7: `fa_bit` = 1 and `n_bit` = 0 exactly when the committed bit 1 (multiframe force) is 1 and `half_sel` is 0. Otherwise `fa_bit` = 0 and `n_bit` = 1.
- R8: A committed byte with bit 0 = 1 is stored whole in `diag_q`. The control fields do not change and no request is raised.
- R9: A write in the same cycle as `frame_sync` is not part of that commit. It is committed at the following frame-sync edge.
- R10: A frame-sync edge with nothing staged leaves every field and `diag_q` unchanged, and it clears both requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write byte |
| frame_sync | input | 1 | One-cycle frame boundary pulse |
| act_req | output | 1 | Activation request, one frame long |
| deact_req | output | 1 | Deactivation request, one frame long |
| dch_b1 | output | 1 | D-channel placed in B1 slot |
| timing_adapt | output | 1 | Adaptive timing compensation select |
| ms_bit | output | 1 | Transmitted M/S bit |
| half_sel | output | 1 | Frame half being transmitted |
| fa_bit | output | 1 | Transmitted Fa bit |
| n_bit | output | 1 | Transmitted N bit |
| diag_q | output | 8 | Diagnostic register contents |

## Verification
Several checks run on every cycle. The active fields and the diagnostic register must stay stable except at a frame-sync edge. A write must always leave the staged byte pending. The requests may change only at frame boundaries and are never high together. Fa is never set in the second half of the frame.

Other behaviour can only be shown by the bench's scenarios. These are the exact field mapping of each of the 256 byte values, last-write-wins within a frame, the deferral of a write that coincides with frame sync, and the clearing of requests after one frame.

// File: rtl/flc_pkg.sv
package flc_pkg;

    localparam int BYTE_W    = 8;
    localparam int B_ACT     = 7;
    localparam int B_DEACT   = 6;
    localparam int B_DCH     = 5;
    localparam int B_TIMING  = 4;
    localparam int B_MS      = 3;
    localparam int B_HALF    = 2;
    localparam int B_MFORCE  = 1;
    localparam int B_SELDIAG = 0;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        logic dch_b1;
        logic timing_adapt;
        logic ms;
        logic half;
        logic mforce;
    } ctrl_t;

    typedef struct packed {
        logic act;
        logic deact;
    } req_t;

    function automatic ctrl_t decode_ctrl(input byte_t b);
        ctrl_t c;
        c.dch_b1       = b[B_DCH];
        c.timing_adapt = b[B_TIMING];
        c.ms           = b[B_MS];
        c.half         = b[B_HALF];
        c.mforce       = b[B_MFORCE];
        return c;
    endfunction

    function automatic req_t decode_req(input byte_t b);
        req_t r;
        r.deact = b[B_DEACT];
        r.act   = b[B_ACT] & ~b[B_DEACT];
        return r;
    endfunction

    function automatic logic targets_diag(input byte_t b);
        return b[B_SELDIAG];
    endfunction

endpackage

// File: rtl/flc_stage.sv
module flc_stage
    import flc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  byte_t wr_data,
    input  logic  frame_sync,
    output byte_t stage_q,
    output logic  pending
);

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            pending <= 1'b0;
        end else if (wr_en) begin
            stage_q <= wr_data;
            pending <= 1'b1;
        end else if (frame_sync) begin
            pending <= 1'b0;
        end
    end

    // R3: a write always leaves its byte staged and pending
    a_r3_last_write_staged: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (pending && stage_q == $past(wr_data)));

    // R10: a sync with no coincident write consumes the staged byte
    a_r10_sync_consumes: assert property (@(posedge clk) disable iff (rst)
        (frame_sync && !wr_en) |=> !pending);

endmodule

// File: rtl/flc_commit.sv
module flc_commit
    import flc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  frame_sync,
    input  logic  pending,
    input  byte_t stage_q,
    output ctrl_t ctrl_q,
    output req_t  req_q,
    output byte_t diag_q
);

    logic do_commit;
    assign do_commit = frame_sync && pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            req_q  <= '0;
            diag_q <= '0;
        end else if (frame_sync) begin
            req_q <= '0;
            if (do_commit) begin
                if (targets_diag(stage_q)) begin
                    diag_q <= stage_q;
                end else begin
                    ctrl_q <= decode_ctrl(stage_q);
                    req_q  <= decode_req(stage_q);
                end
            end
        end
    end

    // R2: active state moves only at a frame boundary
    a_r2_hold_between_syncs: assert property (@(posedge clk) disable iff (rst)
        !frame_sync |=> ($stable(ctrl_q) && $stable(diag_q)));

    // R4: requests change only at a frame boundary, so each lasts one frame
    a_r4_req_frame_aligned: assert property (@(posedge clk) disable iff (rst)
        !frame_sync |=> $stable(req_q));

    // R5: deactivation wins over activation
    a_r5_deact_wins: assert property (@(posedge clk) disable iff (rst)
        !(req_q.act && req_q.deact));

endmodule

// File: rtl/flc_txbits.sv
module flc_txbits
    import flc_pkg::*;
(
    input  ctrl_t ctrl_q,
    output logic  fa_bit,
    output logic  n_bit
);

    logic mframe;
    assign mframe = ctrl_q.mforce & ~ctrl_q.half;
    assign fa_bit = mframe;
    assign n_bit  = ~mframe;

endmodule

// File: rtl/frame_line_ctrl.sv
module frame_line_ctrl
    import flc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       frame_sync,
    output logic       act_req,
    output logic       deact_req,
    output logic       dch_b1,
    output logic       timing_adapt,
    output logic       ms_bit,
    output logic       half_sel,
    output logic       fa_bit,
    output logic       n_bit,
    output logic [7:0] diag_q
);

    byte_t stage_q;
    logic  pending;
    ctrl_t ctrl_q;
    req_t  req_q;

    flc_stage u_stage (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .frame_sync (frame_sync),
        .stage_q    (stage_q),
        .pending    (pending)
    );

    flc_commit u_commit (
        .clk        (clk),
        .rst        (rst),
        .frame_sync (frame_sync),
        .pending    (pending),
        .stage_q    (stage_q),
        .ctrl_q     (ctrl_q),
        .req_q      (req_q),
        .diag_q     (diag_q)
    );

    flc_txbits u_tx (
        .ctrl_q (ctrl_q),
        .fa_bit (fa_bit),
        .n_bit  (n_bit)
    );

    assign act_req      = req_q.act;
    assign deact_req    = req_q.deact;
    assign dch_b1       = ctrl_q.dch_b1;
    assign timing_adapt = ctrl_q.timing_adapt;
    assign ms_bit       = ctrl_q.ms;
    assign half_sel     = ctrl_q.half;

    // R7: the multiframe pattern is never sent in the second half
    a_r7_fa_first_half_only: assert property (@(posedge clk) disable iff (rst)
        fa_bit |-> !half_sel);

endmodule

// File: tb/frame_line_ctrl_tb_top.sv
`timescale 1ns/1ps
module frame_line_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst, wr_en, frame_sync;
    logic [7:0] wr_data;
    logic       act_req, deact_req, dch_b1, timing_adapt, ms_bit, half_sel, fa_bit, n_bit;
    logic [7:0] diag_q;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // bench model
    logic [7:0] m_stage;
    logic       m_pend;
    logic       e_act, e_deact, e_dch, e_tim, e_ms, e_half, e_mf;
    logic [7:0] e_diag;

    always #2 clk = ~clk;

    frame_line_ctrl dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .frame_sync(frame_sync),
        .act_req(act_req), .deact_req(deact_req), .dch_b1(dch_b1), .timing_adapt(timing_adapt),
        .ms_bit(ms_bit), .half_sel(half_sel), .fa_bit(fa_bit), .n_bit(n_bit), .diag_q(diag_q)
    );

    function automatic logic [15:0] expected_vec();
        logic fa;
        fa = e_mf & ~e_half;
        return {e_act, e_deact, e_dch, e_tim, e_ms, e_half, fa, ~fa, e_diag};
    endfunction

    task automatic model_reset();
        m_stage = 8'h00; m_pend = 1'b0;
        e_act = 0; e_deact = 0; e_dch = 0; e_tim = 0; e_ms = 0; e_half = 0; e_mf = 0;
        e_diag = 8'h00;
    endtask

    // one clock: drive at negedge, update model at posedge, return at next negedge
    task automatic cycle(input logic we, input logic [7:0] d, input logic fs);
        wr_en = we; wr_data = d; frame_sync = fs;
        @(posedge clk);
        if (fs) begin
            e_act = 1'b0; e_deact = 1'b0;
            if (m_pend) begin
                if (m_stage[0]) e_diag = m_stage;
                else begin
                    e_dch = m_stage[5]; e_tim = m_stage[4]; e_ms = m_stage[3];
                    e_half = m_stage[2]; e_mf = m_stage[1];
                    e_deact = m_stage[6];
                    e_act = m_stage[7] & ~m_stage[6];
                end
            end
        end
        if (we) begin m_stage = d; m_pend = 1'b1; end
        else if (fs) m_pend = 1'b0;
        @(negedge clk);
        wr_en = 1'b0; frame_sync = 1'b0; wr_data = 8'h00;
    endtask

    task automatic check(input string tag);
        logic [15:0] act_v, exp_v;
        act_v = {act_req, deact_req, dch_b1, timing_adapt, ms_bit, half_sel, fa_bit, n_bit, diag_q};
        exp_v = expected_vec();
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act_v, exp_v);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; frame_sync = 1'b0; wr_data = 8'h00;
        model_reset();
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst = 1'b0;
        check("R1 reset state");

        // sweep every byte value through the commit path
        for (int v = 0; v < 256; v++) begin
            cycle(1'b1, v[7:0], 1'b0);
            cycle(1'b0, 8'h00, 1'b0);
            check("R2 no change before sync");
            cycle(1'b0, 8'h00, 1'b1);
            check("R4 R5 R6 R7 R8 committed byte");
            cycle(1'b0, 8'h00, 1'b0);
            cycle(1'b0, 8'h00, 1'b1);
            check("R10 empty frame keeps fields, ends requests");
        end

        // last write wins within one frame
        for (int k = 0; k < 16; k++) begin
            cycle(1'b1, 8'hFE ^ k[7:0], 1'b0);
            cycle(1'b1, 8'h40, 1'b0);
            cycle(1'b1, {k[3:0], 4'b0100} ^ 8'h80, 1'b0);
            cycle(1'b0, 8'h00, 1'b1);
            check("R3 last write wins");
        end

        // write coincident with sync defers to the next boundary
        cycle(1'b1, 8'h24, 1'b0);
        cycle(1'b1, 8'h9A, 1'b1);
        check("R9 coincident write not committed");
        cycle(1'b0, 8'h00, 1'b0);
        cycle(1'b0, 8'h00, 1'b1);
        check("R9 coincident write committed next frame");
        cycle(1'b1, 8'h55, 1'b1);
        check("R9 coincident write with nothing staged");
        cycle(1'b0, 8'h00, 1'b1);
        check("R9 deferred diag write lands");

        // both request bits: deactivation only
        cycle(1'b1, 8'hC2, 1'b0);
        cycle(1'b0, 8'h00, 1'b1);
        check("R5 both requests set");

        // reset again clears everything
        rst = 1'b1;
        model_reset();
        cycle(1'b0, 8'h00, 1'b0);
        rst = 1'b0;
        check("R1 reset after activity");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule